// File: doc/BRIEF.md
# Sticky Sense and Enable Register

This block is a small control-bus register that watches two general-purpose sense inputs and drives two general-purpose enable outputs. Each sense input is asynchronous. It passes through a two-flop synchronizer and then a duration qualifier. Its status bit is set only when the input has stayed high for a minimum number of clock cycles. Once set, the bit holds its value whatever the pin does afterwards, until software writes a one to that bit position.

The two enable bits are plain read/write bits, and each one drives its own output pin. An interrupt request is raised while any sense bit is set and the interrupt enable bit in a second register is 1. A separate active-low reset pin is qualified in the same way as the sense inputs. When that reset is recognized, every register bit is cleared and the block reports not-ready for a fixed settling time.

Top module: `sense_enable_reg`

## Requirements
- R1: Register layout. At address 0, bit 0 is sense 0, bit 1 is sense 1, bit 2 is enable 0, bit 3 is enable 1, and bits 7..4 read 0. At address 1, bit 0 is the interrupt enable and bits 7..1 read 0. Reads are combinational on `addr_i`, and every bit resets to 0.
- R2: A sense bit is set only after its input has been sampled high on at least `HOLD_CYC` consecutive clock edges (default 8, which is 160 ns at 50 MHz). Shorter pulses leave the bit at 0, and so do two short pulses separated by a one-cycle gap.
- R3: A set sense bit stays 1 after its input returns low, for as long as no clearing write reaches it.
- R4: Writing address 0 with a 1 in a sense bit position clears that bit. A 0 in that position leaves the bit unchanged.
- R5: If a clearing write and a qualified assertion of the same input fall in the same cycle, the bit stays 1. The set wins.
- R6: Writing address 0 loads bits 3..2 into the enable bits. Output `en_o[k]` is 1 exactly when enable bit k is 1, from the cycle after the write.
- R7: `irq_o` is 1 exactly when the interrupt enable bit is 1 and at least one sense bit is 1.
- R8: Driving `soft_rst_ni` low on at least `HOLD_CYC` consecutive clock edges clears every register bit. A shorter low pulse has no effect on register contents or on `ready_o`.
- R9: `ready_o` is low for exactly `SETTLE_CYC` cycles (default 48, which is 960 ns) after a qualified `soft_rst_ni` ends, and also after `rst_ni` is released. While `ready_o` is low, all register bits read 0, `en_o` and `irq_o` are 0, and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| soft_rst_ni | input | 1 | Asynchronous active-low reset request, duration-qualified |
| sense_i | input | SENSE_N | Asynchronous sense inputs, active high |
| en_o | output | EN_N | Enable outputs driven from the enable bits |
| irq_o | output | 1 | Interrupt request |
| ready_o | output | 1 | Low while internal logic settles after a reset |
| addr_i | input | 1 | Register select: 0 = control/status, 1 = interrupt enable |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for the selected register |

## Verification
The bench tries pulses one cycle below the hold threshold, pulses exactly at it, and two short pulses joined by a one-cycle gap. A qualifier that miscounts by one, or that does not restart after a gap, sets the sense bit when it should stay 0, or leaves it at 0 when it should be set. It clears a bit while its input is still held high; a design that lets the clear win loses an event that is still present. It pulses the reset request once one cycle short of the threshold and once at the threshold, measures the exact length of the not-ready window, and writes during that window. A wrong settle count, or a write that gets through, shows up as a wrong count or as enable bits that survive the reset. Random writes, masks and pulse lengths then check the write-one-to-clear behaviour and the interrupt gating against a bench model.

// File: rtl/sense_enable_pkg.sv
package sense_enable_pkg;

  // register select on the control bus
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/se_sync2.sv
// Two-flop synchronizer for one asynchronous level.
module se_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/se_duration_qual.sv
// Raises hit_o on every cycle where level_i has been high for at least
// HOLD_CYC consecutive samples (the current one included).
module se_duration_qual #(
  parameter int HOLD_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic hit_o
);

  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic          run_en;
  logic          at_last;

  assign at_last = (run_q == LAST);

  always_comb begin
    run_d  = run_q;
    run_en = 1'b0;
    if (!level_i) begin
      run_d  = '0;
      run_en = (run_q != '0);
    end else if (!at_last) begin
      run_d  = run_q + 1'b1;
      run_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

  assign hit_o = level_i && at_last;

endmodule

// File: rtl/se_settle_timer.sv
// Holds ready_o low for SETTLE_CYC cycles after the last load_i and after reset.
module se_settle_timer #(
  parameter int SETTLE_CYC = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic ready_o
);

  localparam int TW = $clog2(SETTLE_CYC + 1);
  localparam logic [TW-1:0] FULL = TW'(SETTLE_CYC);

  logic [TW-1:0] left_q;
  logic [TW-1:0] left_d;
  logic          left_en;

  always_comb begin
    left_d  = left_q;
    left_en = 1'b0;
    if (load_i) begin
      left_d  = FULL;
      left_en = 1'b1;
    end else if (left_q != '0) begin
      left_d  = left_q - 1'b1;
      left_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= FULL;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

  assign ready_o = (left_q == '0);

endmodule

// File: rtl/sense_enable_reg.sv
module sense_enable_reg
  import sense_enable_pkg::*;
#(
  parameter int SENSE_N    = 2,
  parameter int EN_N       = 2,
  parameter int DATA_W     = 8,
  parameter int HOLD_CYC   = 8,
  parameter int SETTLE_CYC = 48
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_ni,
  input  logic [SENSE_N-1:0] sense_i,
  output logic [EN_N-1:0]    en_o,
  output logic               irq_o,
  output logic               ready_o,
  input  logic               addr_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o
);

  localparam int EN_LO  = SENSE_N;
  localparam int EN_HI  = SENSE_N + EN_N - 1;
  localparam int CTRL_W = SENSE_N + EN_N;

  // ---------------- sense inputs: synchronize then qualify ----------------
  logic [SENSE_N-1:0] sense_sync;
  logic [SENSE_N-1:0] sense_hit;

  for (genvar i = 0; i < SENSE_N; i++) begin : g_sense
    se_sync2 #(.RST_VAL(1'b0)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (sense_i[i]),
      .q_o    (sense_sync[i])
    );
    se_duration_qual #(.HOLD_CYC(HOLD_CYC)) u_qual (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .level_i (sense_sync[i]),
      .hit_o   (sense_hit[i])
    );
  end

  // ---------------- reset request: synchronize, qualify, settle -----------
  logic soft_sync_n;
  logic rst_hit;
  logic ready;

  se_sync2 #(.RST_VAL(1'b1)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (soft_rst_ni),
    .q_o    (soft_sync_n)
  );

  se_duration_qual #(.HOLD_CYC(HOLD_CYC)) u_rst_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (~soft_sync_n),
    .hit_o   (rst_hit)
  );

  se_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rst_hit),
    .ready_o (ready)
  );

  // ---------------- register bits ----------------
  logic [SENSE_N-1:0] sense_q, sense_d;
  logic [EN_N-1:0]    en_q, en_d;
  logic               irq_en_q, irq_en_d;
  logic               regs_upd;
  logic               wr_ctrl;
  logic               wr_mask;
  logic               hold_clear;

  assign wr_ctrl    = wr_en_i && (reg_sel_e'(addr_i) == SEL_CTRL);
  assign wr_mask    = wr_en_i && (reg_sel_e'(addr_i) == SEL_MASK);
  assign hold_clear = !ready || rst_hit;

  always_comb begin
    sense_d  = sense_q;
    en_d     = en_q;
    irq_en_d = irq_en_q;
    if (hold_clear) begin
      sense_d  = '0;
      en_d     = '0;
      irq_en_d = 1'b0;
    end else begin
      if (wr_ctrl) begin
        sense_d = sense_q & ~wdata_i[SENSE_N-1:0];
        en_d    = wdata_i[EN_HI:EN_LO];
      end
      if (wr_mask) begin
        irq_en_d = wdata_i[0];
      end
      sense_d = sense_d | sense_hit;   // set takes priority over clear
    end
  end

  assign regs_upd = hold_clear || wr_en_i || (|sense_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q  <= '0;
      en_q     <= '0;
      irq_en_q <= 1'b0;
    end else if (regs_upd) begin
      sense_q  <= sense_d;
      en_q     <= en_d;
      irq_en_q <= irq_en_d;
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    rdata_o = '0;
    case (reg_sel_e'(addr_i))
      SEL_CTRL: rdata_o[CTRL_W-1:0] = {en_q, sense_q};
      SEL_MASK: rdata_o[0]          = irq_en_q;
      default:  rdata_o             = '0;
    endcase
  end

  assign en_o    = en_q;
  assign irq_o   = irq_en_q && (|sense_q);
  assign ready_o = ready;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

endmodule

// File: rtl/se_checker.sv
module se_checker #(
  parameter int SENSE_N    = 2,
  parameter int EN_N       = 2,
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 48
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ready_o,
  input logic [EN_N-1:0]    en_o,
  input logic               irq_o,
  input logic               addr_i,
  input logic               wr_en_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [SENSE_N-1:0] sense_q,
  input logic [SENSE_N-1:0] sense_hit
);

  localparam int CW = $clog2(SETTLE_CYC + 2) + 1;

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
    end else if (ready_o) begin
      low_cnt <= '0;
    end else if (low_cnt != '1) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  logic unused_chk;
  assign unused_chk = ^wdata_i;

  for (genvar i = 0; i < SENSE_N; i++) begin : g_bit
    // R3: a set bit survives when no clearing write targets it
    p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && sense_q[i] && !(wr_en_i && !addr_i && wdata_i[i]))
      |=> (sense_q[i] || !ready_o));

    // R4: a clearing write with no qualified assertion clears the bit
    p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && wr_en_i && !addr_i && wdata_i[i] && !sense_hit[i])
      |=> !sense_q[i]);

    // R5: a qualified assertion always leaves the bit set
    p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && sense_hit[i]) |=> (sense_q[i] || !ready_o));
  end

  // R6: enable pins follow the written value
  p_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && wr_en_i && !addr_i)
    |=> ((en_o == $past(wdata_i[SENSE_N+EN_N-1:SENSE_N])) || !ready_o));

  // R7: clearing the interrupt enable silences the request
  p_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && wr_en_i && addr_i && !wdata_i[0]) |=> !irq_o);

  // R9: outputs quiet while not ready
  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> ((en_o == '0) && !irq_o));

  // R9: the not-ready window lasts at least the settle time
  p_settle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (low_cnt >= CW'(SETTLE_CYC)));

endmodule

bind sense_enable_reg se_checker #(
  .SENSE_N    (SENSE_N),
  .EN_N       (EN_N),
  .DATA_W     (DATA_W),
  .SETTLE_CYC (SETTLE_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_o   (ready_o),
  .en_o      (en_o),
  .irq_o     (irq_o),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wdata_i   (wdata_i),
  .sense_q   (sense_q),
  .sense_hit (sense_hit)
);

// File: tb/sense_enable_reg_tb.sv
module sense_enable_reg_tb;

  localparam int HOLD   = 8;
  localparam int SETTLE = 48;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       soft_rst_ni;
  logic [1:0] sense_i;
  logic [1:0] en_o;
  logic       irq_o;
  logic       ready_o;
  logic       addr_i;
  logic       wr_en_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;

  always #10 clk = ~clk;   // 50 MHz

  sense_enable_reg #(
    .SENSE_N(2), .EN_N(2), .DATA_W(8), .HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_ni(soft_rst_ni), .sense_i(sense_i),
    .en_o(en_o), .irq_o(irq_o), .ready_o(ready_o), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // bench model
  logic [1:0] m_sense;
  logic [1:0] m_en;
  logic       m_mask;

  function automatic logic [7:0] exp_ctrl();
    return {4'b0000, m_en, m_sense};
  endfunction

  function automatic logic exp_irq();
    return m_mask && (m_sense != 2'b00);
  endfunction

  function automatic void model_write(input logic a, input logic [7:0] d);
    if (!a) begin
      m_sense = m_sense & ~d[1:0];
      m_en    = d[3:2];
    end else begin
      m_mask = d[0];
    end
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr_i  = a;
    wdata_i = d;
    wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int idx, input int len);
    sense_i[idx] = 1'b1;
    repeat (len) @(negedge clk);
    sense_i[idx] = 1'b0;
    idle(4);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d;
    rd(1'b0, d);
    chk({tag, " ctrl R1"}, {24'd0, d}, {24'd0, exp_ctrl()});
    rd(1'b1, d);
    chk({tag, " mask R1"}, {24'd0, d}, {31'd0, m_mask});
    chk({tag, " en_o R6"}, {30'd0, en_o}, {30'd0, m_en});
    chk({tag, " irq_o R7"}, {31'd0, irq_o}, {31'd0, exp_irq()});
  endtask

  // counts negedges until ready_o is high, starting while it is low
  task automatic count_low(output int cnt);
    cnt = 0;
    while (!ready_o && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int         cnt;
    bit         saw_low;
    void'($urandom(32'd7321));
    rst_ni      = 1'b0;
    soft_rst_ni = 1'b1;
    sense_i     = 2'b00;
    addr_i      = 1'b0;
    wr_en_i     = 1'b0;
    wdata_i     = 8'h00;
    m_sense = 2'b00; m_en = 2'b00; m_mask = 1'b0;
    idle(3);

    // R9: quiet during hardware reset
    chk("R9 ready in reset", {31'd0, ready_o}, 32'd0);
    rd(1'b0, d);
    chk("R9 rdata in reset", {24'd0, d}, 32'd0);

    rst_ni = 1'b1;
    count_low(cnt);
    chk("R9 settle after rst_ni", cnt, SETTLE);
    check_all("R1 reset values");

    // R6: enables
    wr(1'b0, 8'h0C); model_write(1'b0, 8'h0C);
    check_all("R6 both enables");
    wr(1'b0, 8'hF4); model_write(1'b0, 8'hF4);
    check_all("R1 upper bits zero");
    wr(1'b1, 8'hFF); model_write(1'b1, 8'hFF);
    check_all("R1 mask upper zero");

    // R2: threshold
    pulse(0, HOLD - 1);
    check_all("R2 short pulse");
    pulse(0, HOLD);
    m_sense[0] = 1'b1;
    check_all("R2 exact pulse");
    wr(1'b1, 8'h00); model_write(1'b1, 8'h00);
    check_all("R7 masked");
    wr(1'b1, 8'h01); model_write(1'b1, 8'h01);
    check_all("R7 unmasked");

    // R2: gap restarts the count
    sense_i[1] = 1'b1; idle(5);
    sense_i[1] = 1'b0; idle(1);
    sense_i[1] = 1'b1; idle(5);
    sense_i[1] = 1'b0; idle(4);
    check_all("R2 gapped pulses");

    // R3: sticky
    idle(20);
    check_all("R3 sticky after drop");

    // R4: a zero leaves the bit, a one clears it
    wr(1'b0, 8'h06); model_write(1'b0, 8'h06);
    check_all("R4 zero keeps");
    wr(1'b0, 8'h05); model_write(1'b0, 8'h05);
    check_all("R4 one clears");

    // R5: clear while input still held
    sense_i[0] = 1'b1;
    idle(HOLD + 4);
    wr(1'b0, 8'h05);
    rd(1'b0, d);
    chk("R5 set wins", {31'd0, d[0]}, 32'd1);
    sense_i[0] = 1'b0;
    idle(4);
    m_sense = 2'b01; m_en = 2'b01;
    check_all("R5 held state");
    wr(1'b0, 8'h0D); model_write(1'b0, 8'h0D);
    check_all("R4 clear after release");

    // R8: short reset request is ignored
    pulse(1, HOLD + 2);
    m_sense[1] = 1'b1;
    saw_low = 1'b0;
    soft_rst_ni = 1'b0;
    for (int k = 0; k < HOLD - 1; k++) begin
      @(negedge clk);
      if (!ready_o) saw_low = 1'b1;
    end
    soft_rst_ni = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (!ready_o) saw_low = 1'b1;
    end
    chk("R8 short reset ready", {31'd0, saw_low}, 32'd0);
    check_all("R8 short reset keeps");

    // R8 and R9: qualified reset request
    soft_rst_ni = 1'b0;
    idle(HOLD);
    soft_rst_ni = 1'b1;
    cnt = 0;
    while (ready_o && cnt < 20) begin
      @(negedge clk);
      cnt++;
    end
    chk("R8 ready fell", {31'd0, ready_o}, 32'd0);
    rd(1'b0, d);
    chk("R9 ctrl reads 0", {24'd0, d}, 32'd0);
    chk("R9 en_o low", {30'd0, en_o}, 32'd0);
    chk("R9 irq_o low", {31'd0, irq_o}, 32'd0);
    wr(1'b0, 8'h0C);
    wr(1'b1, 8'h01);
    count_low(cnt);
    chk("R9 settle after soft reset", cnt + 2, SETTLE);
    m_sense = 2'b00; m_en = 2'b00; m_mask = 1'b0;
    check_all("R8 cleared R9 writes ignored");

    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      int op;
      op = int'($urandom_range(2, 0));
      if (op == 0) begin
        int idx;
        int len;
        idx = int'($urandom_range(1, 0));
        len = int'($urandom_range(14, 1));
        pulse(idx, len);
        if (len >= HOLD) m_sense[idx] = 1'b1;
        check_all("R2 random pulse");
      end else if (op == 1) begin
        logic [7:0] dv;
        dv = 8'($urandom());
        wr(1'b0, dv); model_write(1'b0, dv);
        check_all("R4 random ctrl write");
      end else begin
        logic [7:0] dv;
        dv = 8'($urandom());
        wr(1'b1, dv); model_write(1'b1, dv);
        check_all("R7 random mask write");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule